// File: doc/BRIEF.md
# Serial Flash Command Guard

This block decides, for an SPI serial flash slave, whether each instruction that the front end has shifted in may take effect. When chip select rises, the front end hands over the decoded opcode, the number of SCK clocks counted while the device was selected, the address and the first data byte. The block then checks the write enable latch, the whole-byte clock count, the block-protect range, the hardware write-protect pin with the status-register lock bit, the deep power-down lockout and the busy state. It raises a one-cycle accept or reject strobe. On an accept it also reports the operation kind to the downstream array sequencer.

Accepted program, erase and status-write operations start an internal busy interval whose length is set by a parameter for each operation kind. The block holds the status register fields it owns. It reports standby once chip select is high, no internal cycle is running and the device is not in deep power-down. The transaction inputs are sampled only in the cycle in which `txn_end` is high. There is no back-pressure: each strobe is a single-cycle event that the sequencer must take as it comes.

Top module: `sflash_guard`

## Requirements
- R1: After reset the status byte reads 0x00, the device is not in deep power-down, and neither strobe is high. The status byte is laid out as: bit0 busy (write in progress), bit1 write enable latch, bits 4:2 block-protect level, bit7 status lock, other bits zero.
- R2: An accepted Write Enable (0x06) sets the latch. An accepted Write Disable (0x04) clears it.
- R3: Write Status (0x01), Page Program (0x02), Sector Erase (0xD8) and Bulk Erase (0xC7) are rejected when the latch is clear. Any rejection leaves the latch unchanged.
- R4: Those four instructions are rejected when the SCK count is not a multiple of eight.
- R5: Block-protect level L=0 protects nothing and L=7 protects the whole array. For L from 1 to 6, the protected region is the top 2^(L-7) of the address space, i.e. the addresses whose top 7-L bits are all ones. Program or Sector Erase to a protected address is rejected. Bulk Erase is rejected whenever L is nonzero.
- R6: When `wp_n` is low and the status lock bit (bit7) is set, Write Status is rejected. With `wp_n` high, or the lock bit clear, the pin has no effect.
- R7: An accepted Write Status loads L from data bits 4:2 and the lock bit from data bit7, at once. Each accepted modifying instruction holds busy high for its parameterised cycle count (Page Program: PP_CYC, default 24 cycles). The latch clears in the cycle busy ends.
- R8: While busy, Read Status (0x05) is still accepted. Every other instruction gives no strobe and has no effect.
- R9: Deep Power-down (0xB9) enters deep power-down. There, only Release (0xAB) is acted on, and it leaves the mode. All other instructions give no strobe and change nothing.
- R10: `standby` is high exactly when `cs_n` is high, busy is low and the device is not in deep power-down. Chip select going high during an internal cycle therefore leaves `standby` low until that cycle ends.
- R11: The strobes appear in the cycle after `txn_end`. An accept carries the kind code on `acc_kind`: 1 WREN, 2 WRDI, 3 RDSR, 4 WRSR, 5 PP, 6 SE, 7 BE, 8 DP, 9 RES. An unknown opcode gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cs_n | input | 1 | Chip select level, low while selected |
| txn_end | input | 1 | One-cycle pulse at chip-select rise carrying a finished transaction |
| txn_opcode | input | 8 | Decoded instruction byte |
| txn_bits | input | NBIT_W | SCK clocks counted in the transaction |
| txn_addr | input | ADDR_W | Target address |
| txn_data | input | 8 | First data byte (status value for Write Status) |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Status byte |
| busy | output | 1 | Internal cycle running |
| deep_pd | output | 1 | Deep power-down active |
| standby | output | 1 | Deselected and idle |
| acc_stb | output | 1 | Instruction accepted (one cycle) |
| rej_stb | output | 1 | Instruction rejected (one cycle) |
| acc_kind | output | 4 | Operation kind of the accepted instruction, 0 otherwise |

## Verification
A latch that is wrong inside the block shows at the next modifying instruction. It turns an expected accept into a reject or the reverse, one cycle after `txn_end`, and it is also visible at once in status bit1. A stale protect level or lock bit shows only when a later program, erase or status write hits the boundary. For that reason the stimulus deliberately aims at the first protected address and at the pin-and-lock combination. A busy counter of the wrong length moves the falling edge of `busy` and of `standby`, and the move is counted to the exact cycle.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  typedef enum logic [3:0] {
    OPK_NONE = 4'd0,
    OPK_WREN = 4'd1,
    OPK_WRDI = 4'd2,
    OPK_RDSR = 4'd3,
    OPK_WRSR = 4'd4,
    OPK_PP   = 4'd5,
    OPK_SE   = 4'd6,
    OPK_BE   = 4'd7,
    OPK_DP   = 4'd8,
    OPK_RES  = 4'd9
  } op_kind_e;

  localparam int SR_BUSY = 0;
  localparam int SR_WEL  = 1;
  localparam int SR_BP_LO = 2;
  localparam int SR_LOCK = 7;

  function automatic op_kind_e decode_op(input logic [7:0] code);
    case (code)
      8'h06:   return OPK_WREN;
      8'h04:   return OPK_WRDI;
      8'h05:   return OPK_RDSR;
      8'h01:   return OPK_WRSR;
      8'h02:   return OPK_PP;
      8'hD8:   return OPK_SE;
      8'hC7:   return OPK_BE;
      8'hB9:   return OPK_DP;
      8'hAB:   return OPK_RES;
      default: return OPK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sfg_protect.sv
module sfg_protect #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        level,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP_BITS = 6;

  logic [2:0] need;
  logic       all_ones;

  // Level L protects the addresses whose top (7-L) bits are all ones.
  always_comb begin
    need     = 3'd7 - level;
    all_ones = 1'b1;
    for (int i = 0; i < TOP_BITS; i++) begin
      if (3'(i) < need) all_ones = all_ones & addr[ADDR_W-1-i];
    end
    hit = (level != 3'd0) && all_ones;
  end

  assert_full_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 3'd7) |-> hit);
  assert_zero_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 3'd0) |-> !hit);
  assert_bottom_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level != 3'd7 && addr[ADDR_W-1] == 1'b0) |-> !hit);

endmodule

// File: rtl/sfg_busy_timer.sv
module sfg_busy_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             busy,
  output logic             done
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == TMR_W'(1));

  assert_load_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt == '0));
  assert_load_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

endmodule

// File: rtl/sflash_guard.sv
module sflash_guard
  import sfg_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NBIT_W = 16,
  parameter int TMR_W  = 8,
  parameter int PP_CYC = 24,
  parameter int SE_CYC = 40,
  parameter int BE_CYC = 64,
  parameter int SR_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              txn_end,
  input  logic [7:0]        txn_opcode,
  input  logic [NBIT_W-1:0] txn_bits,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [7:0]        txn_data,
  input  logic              wp_n,
  output logic [7:0]        status,
  output logic              busy,
  output logic              deep_pd,
  output logic              standby,
  output logic              acc_stb,
  output logic              rej_stb,
  output logic [3:0]        acc_kind
);
  op_kind_e         kind;
  op_kind_e         kind_q;
  logic             whole_bytes;
  logic             hw_lock;
  logic             prot_hit;
  logic             busy_w;
  logic             tmr_done;
  logic             act_acc;
  logic             act_rej;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             wel;
  logic             lock_q;
  logic [2:0]       level_q;
  logic             dp_q;

  assign kind        = decode_op(txn_opcode);
  assign whole_bytes = (txn_bits[2:0] == 3'd0);
  assign hw_lock     = !wp_n && lock_q;

  sfg_protect #(.ADDR_W(ADDR_W)) u_protect (
    .clk   (clk),
    .rst_n (rst_n),
    .level (level_q),
    .addr  (txn_addr),
    .hit   (prot_hit)
  );

  sfg_busy_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .busy     (busy_w),
    .done     (tmr_done)
  );

  // Acceptance decision for the transaction presented with txn_end.
  always_comb begin
    act_acc  = 1'b0;
    act_rej  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (txn_end) begin
      if (busy_w) begin
        act_acc = (kind == OPK_RDSR);
      end else if (dp_q) begin
        act_acc = (kind == OPK_RES);
      end else begin
        case (kind)
          OPK_WREN, OPK_WRDI, OPK_RDSR, OPK_DP, OPK_RES: act_acc = 1'b1;
          OPK_WRSR: begin
            act_rej = !whole_bytes || !wel || hw_lock;
            tmr_val = TMR_W'(SR_CYC);
          end
          OPK_PP: begin
            act_rej = !whole_bytes || !wel || prot_hit;
            tmr_val = TMR_W'(PP_CYC);
          end
          OPK_SE: begin
            act_rej = !whole_bytes || !wel || prot_hit;
            tmr_val = TMR_W'(SE_CYC);
          end
          OPK_BE: begin
            act_rej = !whole_bytes || !wel || (level_q != 3'd0);
            tmr_val = TMR_W'(BE_CYC);
          end
          default: ;
        endcase
        if (kind inside {OPK_WRSR, OPK_PP, OPK_SE, OPK_BE}) begin
          act_acc  = !act_rej;
          tmr_load = !act_rej;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel     <= 1'b0;
      lock_q  <= 1'b0;
      level_q <= 3'd0;
      dp_q    <= 1'b0;
      acc_stb <= 1'b0;
      rej_stb <= 1'b0;
      kind_q  <= OPK_NONE;
    end else begin
      acc_stb <= act_acc;
      rej_stb <= act_rej;
      kind_q  <= act_acc ? kind : OPK_NONE;
      if (tmr_done) wel <= 1'b0;
      if (act_acc) begin
        case (kind)
          OPK_WREN: wel <= 1'b1;
          OPK_WRDI: wel <= 1'b0;
          OPK_WRSR: begin
            level_q <= txn_data[SR_BP_LO +: 3];
            lock_q  <= txn_data[SR_LOCK];
          end
          OPK_DP:   dp_q <= 1'b1;
          OPK_RES:  dp_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    status                  = '0;
    status[SR_BUSY]         = busy_w;
    status[SR_WEL]          = wel;
    status[SR_BP_LO +: 3]   = level_q;
    status[SR_LOCK]         = lock_q;
  end

  assign busy     = busy_w;
  assign deep_pd  = dp_q;
  assign standby  = cs_n && !busy_w && !dp_q;
  assign acc_kind = kind_q;

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_stb && rej_stb));
  assert_reject_keeps_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_rej |=> (rej_stb && wel == $past(wel)));
  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && busy_w && kind != OPK_RDSR) |=> (!acc_stb && !rej_stb));
  assert_dp_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && dp_q && kind != OPK_RES) |=> (dp_q && !acc_stb && !rej_stb && $stable(wel)));
  assert_wel_clears_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |=> (!wel && !busy_w));
  assert_lock_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && kind == OPK_WRSR && !wp_n && lock_q) |=> (!acc_stb && $stable(level_q)));

endmodule

// File: tb/sflash_guard_test.sv
module sflash_guard_test;

  localparam int ADDR_W = 24;
  localparam int NBIT_W = 16;
  localparam int PP_LEN = 24;

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] nbits;
    logic [23:0] addr;
    logic [7:0]  data;
    logic        wp;
    logic [1:0]  exp;    // 2'b10 accept, 2'b01 reject, 2'b00 no strobe
    logic [7:0]  exp_sr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [0:NV-1] = '{
    '{8'h02, 16'd32, 24'h000000, 8'h00, 1'b1, 2'b01, 8'h00, 8'd3},  // R3 no latch
    '{8'h06, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b10, 8'h02, 8'd2},  // R2
    '{8'h02, 16'd36, 24'h000100, 8'h00, 1'b1, 2'b01, 8'h02, 8'd4},  // R4 partial byte
    '{8'h02, 16'd40, 24'h000100, 8'h00, 1'b1, 2'b10, 8'h00, 8'd7},  // R7
    '{8'h06, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b10, 8'h02, 8'd2},  // R2
    '{8'h01, 16'd12, 24'h000000, 8'h18, 1'b1, 2'b01, 8'h02, 8'd4},  // R4
    '{8'h01, 16'd16, 24'h000000, 8'h18, 1'b1, 2'b10, 8'h18, 8'd7},  // R7 level 6
    '{8'h06, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b10, 8'h1A, 8'd2},  // R2
    '{8'h02, 16'd40, 24'h800000, 8'h00, 1'b1, 2'b01, 8'h1A, 8'd5},  // R5 upper half
    '{8'hD8, 16'd32, 24'h7FFFFF, 8'h00, 1'b1, 2'b10, 8'h18, 8'd5},  // R5 just below
    '{8'h06, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b10, 8'h1A, 8'd2},  // R2
    '{8'hC7, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b01, 8'h1A, 8'd5},  // R5 bulk blocked
    '{8'h01, 16'd16, 24'h000000, 8'h80, 1'b1, 2'b10, 8'h80, 8'd7},  // R7 lock set
    '{8'h06, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b10, 8'h82, 8'd2},  // R2
    '{8'hC7, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b10, 8'h80, 8'd5},  // R5 bulk ok
    '{8'h06, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b10, 8'h82, 8'd2},  // R2
    '{8'h01, 16'd16, 24'h000000, 8'h00, 1'b0, 2'b01, 8'h82, 8'd6},  // R6 pin low + lock
    '{8'h04, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b10, 8'h80, 8'd2},  // R2 disable
    '{8'h06, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b10, 8'h82, 8'd2},  // R2
    '{8'h01, 16'd16, 24'h000000, 8'h1C, 1'b1, 2'b10, 8'h1C, 8'd6},  // R6 pin high
    '{8'h06, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b10, 8'h1E, 8'd2},  // R2
    '{8'h02, 16'd40, 24'h000000, 8'h00, 1'b1, 2'b01, 8'h1E, 8'd5},  // R5 level 7
    '{8'h01, 16'd16, 24'h000000, 8'h00, 1'b0, 2'b10, 8'h00, 8'd6},  // R6 lock clear
    '{8'h9F, 16'd8,  24'h000000, 8'h00, 1'b1, 2'b00, 8'h00, 8'd11}, // R11 unknown
    '{8'h01, 16'd16, 24'h000000, 8'h00, 1'b1, 2'b01, 8'h00, 8'd3},  // R3
    '{8'h05, 16'd16, 24'h000000, 8'h00, 1'b1, 2'b10, 8'h00, 8'd11}  // R11
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs_n = 1'b1;
  logic              txn_end = 1'b0;
  logic [7:0]        txn_opcode = '0;
  logic [NBIT_W-1:0] txn_bits = '0;
  logic [ADDR_W-1:0] txn_addr = '0;
  logic [7:0]        txn_data = '0;
  logic              wp_n = 1'b1;
  logic [7:0]        status;
  logic              busy;
  logic              deep_pd;
  logic              standby;
  logic              acc_stb;
  logic              rej_stb;
  logic [3:0]        acc_kind;

  int n_checks = 0;
  int n_fail   = 0;
  logic got_acc, got_rej;
  logic [3:0] got_kind;

  always #10 clk = ~clk;

  sflash_guard uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .txn_end(txn_end),
    .txn_opcode(txn_opcode), .txn_bits(txn_bits), .txn_addr(txn_addr),
    .txn_data(txn_data), .wp_n(wp_n), .status(status), .busy(busy),
    .deep_pd(deep_pd), .standby(standby), .acc_stb(acc_stb),
    .rej_stb(rej_stb), .acc_kind(acc_kind)
  );

  function automatic logic [3:0] exp_kind(input logic [7:0] op);
    case (op)
      8'h06: return 4'd1;  8'h04: return 4'd2;  8'h05: return 4'd3;
      8'h01: return 4'd4;  8'h02: return 4'd5;  8'hD8: return 4'd6;
      8'hC7: return 4'd7;  8'hB9: return 4'd8;  8'hAB: return 4'd9;
      default: return 4'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_txn(input logic [7:0] op, input logic [15:0] nb,
                        input logic [23:0] ad, input logic [7:0] dt);
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    txn_opcode = op; txn_bits = nb; txn_addr = ad; txn_data = dt;
    txn_end = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    txn_end = 1'b0;
    got_acc = acc_stb; got_rej = rej_stb; got_kind = acc_kind;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int blen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", {24'd0, status}, 32'h00);
    check("R1 deep_pd", {31'd0, deep_pd}, 32'd0);
    check("R1 strobes", {30'd0, acc_stb, rej_stb}, 32'd0);
    check("R10 standby idle", {31'd0, standby}, 32'd1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      wp_n = VECS[v].wp;
      do_txn(VECS[v].op, VECS[v].nbits, VECS[v].addr, VECS[v].data);
      n_checks++;
      if ({got_acc, got_rej} !== VECS[v].exp ||
          (got_acc && got_kind !== exp_kind(VECS[v].op))) begin
        n_fail++;
        $display("FAIL R%0d vec %0d strobe: got %b kind %0d expected %b kind %0d",
                 VECS[v].req, v, {got_acc, got_rej}, got_kind, VECS[v].exp,
                 exp_kind(VECS[v].op));
      end
      wait_idle();
      n_checks++;
      if (status !== VECS[v].exp_sr) begin
        n_fail++;
        $display("FAIL R%0d vec %0d status: got %h expected %h",
                 VECS[v].req, v, status, VECS[v].exp_sr);
      end
    end
    wp_n = 1'b1;

    // R7 busy length for Page Program
    do_txn(8'h06, 16'd8, 24'h0, 8'h0);
    do_txn(8'h02, 16'd40, 24'h000010, 8'h0);
    check("R7 pp accept", {31'd0, got_acc}, 32'd1);
    blen = 0;
    while (busy && blen < 500) begin blen++; @(negedge clk); end
    check("R7 pp busy length", blen, PP_LEN);
    check("R7 wel cleared", {24'd0, status}, 32'h00);

    // R8 / R10 behaviour during an erase
    do_txn(8'h06, 16'd8, 24'h0, 8'h0);
    do_txn(8'hD8, 16'd32, 24'h000000, 8'h0);
    check("R10 standby low while busy", {31'd0, standby}, 32'd0);
    check("R7 status busy", {24'd0, status}, 32'h03);
    do_txn(8'h04, 16'd8, 24'h0, 8'h0);
    check("R8 wrdi ignored", {30'd0, got_acc, got_rej}, 32'd0);
    check("R8 latch kept", {24'd0, status}, 32'h03);
    do_txn(8'h05, 16'd16, 24'h0, 8'h0);
    check("R8 rdsr accepted", {27'd0, got_acc, got_kind}, {27'd0, 1'b1, 4'd3});
    wait_idle();
    check("R10 standby after busy", {31'd0, standby}, 32'd1);
    check("R7 idle status", {24'd0, status}, 32'h00);

    // R9 deep power-down
    do_txn(8'hB9, 16'd8, 24'h0, 8'h0);
    check("R9 enter", {27'd0, got_acc, got_kind}, {27'd0, 1'b1, 4'd8});
    check("R9 deep_pd", {31'd0, deep_pd}, 32'd1);
    check("R10 standby low in dp", {31'd0, standby}, 32'd0);
    do_txn(8'h06, 16'd8, 24'h0, 8'h0);
    check("R9 wren ignored", {30'd0, got_acc, got_rej}, 32'd0);
    check("R9 latch untouched", {24'd0, status}, 32'h00);
    do_txn(8'hC7, 16'd8, 24'h0, 8'h0);
    check("R9 erase ignored", {30'd0, got_acc, got_rej}, 32'd0);
    do_txn(8'hAB, 16'd8, 24'h0, 8'h0);
    check("R9 release", {27'd0, got_acc, got_kind}, {27'd0, 1'b1, 4'd9});
    check("R9 left dp", {31'd0, deep_pd}, 32'd0);
    do_txn(8'h06, 16'd8, 24'h0, 8'h0);
    check("R2 wren after wake", {24'd0, status}, 32'h02);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule